// File: doc/BRIEF.md
# Capability jump target checker

This stage evaluates a capability-aware jump in a 32-bit core where compressed instructions are always available. It handles two kinds of jump: a register-indirect jump, whose destination is a source capability's address plus a sign-extended immediate, and a direct jump, whose destination is the current PC plus an immediate. For each request it produces the target PC, the program-counter capability that the jump installs, the link address, and two fault flags: one for permission violations and one for bounds faults.

The source capability arrives with its bounds already decoded into a 32-bit base and a 33-bit top. The bounds check compares the target directly against a two-byte fetch window. No representability check is made. The installed capability keeps the source address rather than taking the target. An odd base is never a fault. A permission violation masks any bounds fault. A commit output rises only for a fault-free request, so the surrounding pipeline updates the program-counter capability only when commit is high. The stage registers its results once, which gives a latency of one cycle.

Top module: `cj_jump_check`

## Requirements
- R1: The target PC is the sum src_addr + imm (for the indirect jump, jump_kind = 0) or the sum pc + imm (for the direct jump, jump_kind = 1), taken modulo 2^32, with bit 0 then cleared.
- R2: For the indirect jump, the new capability equals the source capability unsealed: the otype is 0, and the tag, perms, base, top and address (src_addr, not the target) are copied. For the direct jump, the new capability is the current PCC with the address pc and otype 0.
- R3: A bounds fault is raised unless base <= target and target + 2 <= top. The comparison is 33 bits wide and uses the bounds of the new capability.
- R4: A target with bit 1 set, an odd base, or a target that cannot be represented raises no fault when it lies inside the bounds.
- R5: The indirect jump raises a permission violation when src_tag is 0, when perms bit EXEC_BIT (default 1) is 0, or when the otype is above SENTRY_MAX (default 3). An otype of 0 means unsealed. The direct jump never raises a permission violation.
- R6: When a permission violation is raised, the bounds fault flag is 0.
- R7: The link address is pc + 4, or pc + 2 when is_compressed is 1. The link tag equals pcc_tag.
- R8: commit is 1 exactly when out_valid is 1 and neither fault flag is set.
- R9: All outputs are registered once. out_valid follows in_valid one cycle later. Reset clears out_valid, commit and both fault flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A jump request is present |
| jump_kind | input | 1 | 0 = register-indirect, 1 = direct |
| is_compressed | input | 1 | The jump has a 16-bit encoding |
| src_tag | input | 1 | Source capability tag |
| src_otype | input | 3 | Source object type, 0 = unsealed |
| src_perms | input | 6 | Source permissions |
| src_addr | input | 32 | Source address |
| src_base | input | 32 | Source decoded base |
| src_top | input | 33 | Source decoded top |
| imm | input | 32 | Sign-extended immediate |
| pc | input | 32 | Current PC |
| pcc_tag | input | 1 | Current PCC tag |
| pcc_perms | input | 6 | Current PCC permissions |
| pcc_base | input | 32 | Current PCC base |
| pcc_top | input | 33 | Current PCC top |
| out_valid | output | 1 | Result valid |
| tgt_pc | output | 32 | Target PC |
| npcc_tag | output | 1 | New PCC tag |
| npcc_otype | output | 3 | New PCC object type |
| npcc_perms | output | 6 | New PCC permissions |
| npcc_addr | output | 32 | New PCC address |
| npcc_base | output | 32 | New PCC base |
| npcc_top | output | 33 | New PCC top |
| perm_vio | output | 1 | Permission violation |
| bound_fault | output | 1 | Bounds fault |
| link_addr | output | 32 | Link address |
| link_tag | output | 1 | Link capability tag |
| commit | output | 1 | PCC may be updated |

## Verification
Some properties are checked on every cycle: faults masking commit, a permission violation masking a bounds fault, an even target, an unsealed new capability, the one-cycle valid timing, the link arithmetic, and the rule that a direct jump never raises a permission violation. Other behaviours show only in the bench scenarios. These are the exact bounds edges (a target at the base, at top-2, at top-1 and at top), sums that wrap, an odd base or a target with bit 1 set that is accepted, each separate permission cause, and the new address being kept as src_addr rather than the target.

// File: rtl/cj_pkg.sv
package cj_pkg;
    parameter int unsigned CJ_XLEN   = 32;
    parameter int unsigned CJ_TOP_W  = CJ_XLEN + 1;
    parameter int unsigned CJ_PERM_W = 6;
    parameter int unsigned CJ_OTYPE_W = 3;

    typedef enum logic {
        JK_INDIRECT = 1'b0,
        JK_DIRECT   = 1'b1
    } jump_kind_e;

    typedef struct packed {
        logic                    tag;
        logic [CJ_OTYPE_W-1:0]   otype;
        logic [CJ_PERM_W-1:0]    perms;
        logic [CJ_XLEN-1:0]      addr;
        logic [CJ_XLEN-1:0]      base;
        logic [CJ_TOP_W-1:0]     top;
    } cap_t;

    typedef struct packed {
        logic                    valid;
        logic [CJ_XLEN-1:0]      tgt;
        cap_t                    ncap;
        logic                    pv;
        logic                    bf;
        logic [CJ_XLEN-1:0]      link;
        logic                    ltag;
        logic                    commit;
    } stage_t;
endpackage

// File: rtl/cj_target.sv
module cj_target #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] origin,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] sum;
    always_comb begin
        sum    = origin + offset;
        target = {sum[XLEN-1:1], 1'b0};
    end
endmodule

// File: rtl/cj_bounds.sv
module cj_bounds #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned FETCH = 2
) (
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN:0]   top,
    output logic            fault
);
    localparam int unsigned W = XLEN + 1;
    logic [W-1:0] lo_ext;
    logic [W-1:0] hi_ext;
    logic         below;
    logic         above;
    always_comb begin
        lo_ext = {1'b0, target};
        hi_ext = lo_ext + W'(FETCH);
        below  = lo_ext < {1'b0, base};
        above  = hi_ext > top;
        fault  = below | above;
    end
endmodule

// File: rtl/cj_perm.sv
module cj_perm #(
    parameter int unsigned PERM_W     = 6,
    parameter int unsigned OTYPE_W    = 3,
    parameter int unsigned EXEC_BIT   = 1,
    parameter int unsigned SENTRY_MAX = 3
) (
    input  logic               check_en,
    input  logic               tag,
    input  logic [PERM_W-1:0]  perms,
    input  logic [OTYPE_W-1:0] otype,
    output logic               vio
);
    logic no_tag;
    logic no_exec;
    logic bad_seal;
    always_comb begin
        no_tag   = ~tag;
        no_exec  = ~perms[EXEC_BIT];
        bad_seal = otype > OTYPE_W'(SENTRY_MAX);
        vio      = check_en & (no_tag | no_exec | bad_seal);
    end
endmodule

// File: rtl/cj_jump_check.sv
module cj_jump_check
    import cj_pkg::*;
#(
    parameter int unsigned EXEC_BIT   = 1,
    parameter int unsigned SENTRY_MAX = 3,
    parameter int unsigned FETCH      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  jump_kind,
    input  logic                  is_compressed,
    input  logic                  src_tag,
    input  logic [CJ_OTYPE_W-1:0] src_otype,
    input  logic [CJ_PERM_W-1:0]  src_perms,
    input  logic [CJ_XLEN-1:0]    src_addr,
    input  logic [CJ_XLEN-1:0]    src_base,
    input  logic [CJ_TOP_W-1:0]   src_top,
    input  logic [CJ_XLEN-1:0]    imm,
    input  logic [CJ_XLEN-1:0]    pc,
    input  logic                  pcc_tag,
    input  logic [CJ_PERM_W-1:0]  pcc_perms,
    input  logic [CJ_XLEN-1:0]    pcc_base,
    input  logic [CJ_TOP_W-1:0]   pcc_top,
    output logic                  out_valid,
    output logic [CJ_XLEN-1:0]    tgt_pc,
    output logic                  npcc_tag,
    output logic [CJ_OTYPE_W-1:0] npcc_otype,
    output logic [CJ_PERM_W-1:0]  npcc_perms,
    output logic [CJ_XLEN-1:0]    npcc_addr,
    output logic [CJ_XLEN-1:0]    npcc_base,
    output logic [CJ_TOP_W-1:0]   npcc_top,
    output logic                  perm_vio,
    output logic                  bound_fault,
    output logic [CJ_XLEN-1:0]    link_addr,
    output logic                  link_tag,
    output logic                  commit
);
    localparam logic [CJ_XLEN-1:0] STEP_FULL = CJ_XLEN'(4);
    localparam logic [CJ_XLEN-1:0] STEP_HALF = CJ_XLEN'(2);

    jump_kind_e      kind;
    logic [CJ_XLEN-1:0] origin;
    logic [CJ_XLEN-1:0] target;
    cap_t            src_cap;
    cap_t            pcc_cap;
    cap_t            new_cap;
    logic            pv_raw;
    logic            bf_raw;
    stage_t          st_d;
    stage_t          st_q;

    always_comb begin
        kind    = jump_kind_e'(jump_kind);
        src_cap = '{tag: src_tag, otype: src_otype, perms: src_perms,
                    addr: src_addr, base: src_base, top: src_top};
        pcc_cap = '{tag: pcc_tag, otype: '0, perms: pcc_perms,
                    addr: pc, base: pcc_base, top: pcc_top};
        if (kind == JK_INDIRECT) begin
            origin  = src_addr;
            new_cap = src_cap;
        end else begin
            origin  = pc;
            new_cap = pcc_cap;
        end
        new_cap.otype = '0;
    end

    cj_target #(.XLEN(CJ_XLEN)) i_target (
        .origin (origin),
        .offset (imm),
        .target (target)
    );

    cj_bounds #(.XLEN(CJ_XLEN), .FETCH(FETCH)) i_bounds (
        .target (target),
        .base   (new_cap.base),
        .top    (new_cap.top),
        .fault  (bf_raw)
    );

    cj_perm #(
        .PERM_W     (CJ_PERM_W),
        .OTYPE_W    (CJ_OTYPE_W),
        .EXEC_BIT   (EXEC_BIT),
        .SENTRY_MAX (SENTRY_MAX)
    ) i_perm (
        .check_en (kind == JK_INDIRECT),
        .tag      (src_tag),
        .perms    (src_perms),
        .otype    (src_otype),
        .vio      (pv_raw)
    );

    always_comb begin
        st_d        = '0;
        st_d.valid  = in_valid;
        if (in_valid) begin
            st_d.tgt    = target;
            st_d.ncap   = new_cap;
            st_d.pv     = pv_raw;
            st_d.bf     = bf_raw & ~pv_raw;
            st_d.link   = pc + (is_compressed ? STEP_HALF : STEP_FULL);
            st_d.ltag   = pcc_tag;
            st_d.commit = ~pv_raw & ~bf_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign tgt_pc      = st_q.tgt;
    assign npcc_tag    = st_q.ncap.tag;
    assign npcc_otype  = st_q.ncap.otype;
    assign npcc_perms  = st_q.ncap.perms;
    assign npcc_addr   = st_q.ncap.addr;
    assign npcc_base   = st_q.ncap.base;
    assign npcc_top    = st_q.ncap.top;
    assign perm_vio    = st_q.pv;
    assign bound_fault = st_q.bf;
    assign link_addr   = st_q.link;
    assign link_tag    = st_q.ltag;
    assign commit      = st_q.commit;
endmodule

// File: rtl/cj_jump_check_sva.sv
module cj_jump_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        jump_kind,
    input logic        is_compressed,
    input logic [31:0] pc,
    input logic        out_valid,
    input logic [31:0] tgt_pc,
    input logic [2:0]  npcc_otype,
    input logic        perm_vio,
    input logic        bound_fault,
    input logic [31:0] link_addr,
    input logic        commit
);
    // R8
    commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (out_valid && !perm_vio && !bound_fault));
    // R6
    fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_vio |-> !bound_fault);
    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!perm_vio && !bound_fault && !commit));
    // R1
    tgt_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !tgt_pc[0]);
    // R2
    unsealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (npcc_otype == 3'd0));
    // R5
    direct_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && jump_kind) |=> !perm_vio);
    // R7
    link_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (link_addr == $past(pc) + ($past(is_compressed) ? 32'd2 : 32'd4)));
endmodule

bind cj_jump_check cj_jump_check_sva i_sva (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .jump_kind(jump_kind),
    .is_compressed(is_compressed), .pc(pc), .out_valid(out_valid),
    .tgt_pc(tgt_pc), .npcc_otype(npcc_otype), .perm_vio(perm_vio),
    .bound_fault(bound_fault), .link_addr(link_addr), .commit(commit)
);

// File: tb/test_cj_jump_check.sv
module test_cj_jump_check;
    localparam int PERIOD = 10;

    typedef struct {
        logic [31:0] tgt;
        logic        ntag;
        logic [2:0]  notype;
        logic [31:0] naddr;
        logic [31:0] nbase;
        logic [32:0] ntop;
        logic        pv;
        logic        bf;
        logic [31:0] link;
        logic        ltag;
        logic        commit;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, jump_kind = 0, is_compressed = 0;
    logic src_tag = 0; logic [2:0] src_otype = 0; logic [5:0] src_perms = 0;
    logic [31:0] src_addr = 0, src_base = 0, imm = 0, pc = 0, pcc_base = 0;
    logic [32:0] src_top = 0, pcc_top = 0;
    logic pcc_tag = 0; logic [5:0] pcc_perms = 0;
    logic out_valid, npcc_tag, perm_vio, bound_fault, link_tag, commit;
    logic [31:0] tgt_pc, npcc_addr, npcc_base, link_addr;
    logic [2:0] npcc_otype; logic [5:0] npcc_perms; logic [32:0] npcc_top;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    cj_jump_check i_cj_jump_check (.*);

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic exp_t model();
        exp_t e;
        logic [31:0] o, s;
        logic [33:0] lo, hi;
        o = jump_kind ? pc : src_addr;
        s = o + imm;
        e.tgt = {s[31:1], 1'b0};
        e.ntag   = jump_kind ? pcc_tag : src_tag;
        e.notype = 3'd0;
        e.naddr  = jump_kind ? pc : src_addr;
        e.nbase  = jump_kind ? pcc_base : src_base;
        e.ntop   = jump_kind ? pcc_top : src_top;
        e.pv = !jump_kind && (!src_tag || !src_perms[1] || src_otype > 3'd3);
        lo = {2'b0, e.tgt};
        hi = lo + 34'd2;
        e.bf = !e.pv && ((lo < {2'b0, e.nbase}) || (hi > {1'b0, e.ntop}));
        e.link = pc + (is_compressed ? 32'd2 : 32'd4);
        e.ltag = pcc_tag;
        e.commit = !e.pv && !e.bf;
        return e;
    endfunction

    task automatic drive(input logic kind, input logic cmp, input logic tg, input logic [2:0] ot,
                         input logic [5:0] pm, input logic [31:0] a, input logic [31:0] b,
                         input logic [32:0] t, input logic [31:0] im, input logic [31:0] p);
        @(negedge clk);
        jump_kind = kind; is_compressed = cmp; src_tag = tg; src_otype = ot; src_perms = pm;
        src_addr = a; src_base = b; src_top = t; imm = im; pc = p;
        pcc_tag = 1; pcc_perms = 6'h3f; pcc_base = 32'h0000_1000; pcc_top = 33'h0_0000_2000;
        in_valid = 1;
        sb.push_back(model());
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (out_valid) begin
                if (sb.size() == 0) chk(0, "R9", 33'(out_valid), 33'd0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(tgt_pc == e.tgt, "R1 tgt", 33'(tgt_pc), 33'(e.tgt));
                    chk(npcc_addr == e.naddr && npcc_otype == e.notype && npcc_tag == e.ntag
                        && npcc_base == e.nbase && npcc_top == e.ntop,
                        "R2 ncap", 33'(npcc_addr), 33'(e.naddr));
                    chk(bound_fault == e.bf, "R3/R4 bound", 33'(bound_fault), 33'(e.bf));
                    chk(perm_vio == e.pv, "R5/R6 perm", 33'(perm_vio), 33'(e.pv));
                    chk(link_addr == e.link && link_tag == e.ltag, "R7 link", 33'(link_addr), 33'(e.link));
                    chk(commit == e.commit, "R8 commit", 33'(commit), 33'(e.commit));
                end
            end
        end
    end

    initial begin : watchdog
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (2) @(negedge clk);
        // R9 reset state
        chk(!out_valid && !commit && !perm_vio && !bound_fault, "R9 reset", 33'(out_valid), 33'd0);
        rst_n = 1;
        // R3 target at base, top-2 ok, top-1 fault, top fault, below base fault
        drive(0, 0, 1, 0, 6'h02, 32'h100, 32'h100, 33'h200, 32'h0, 32'h1100);
        drive(0, 0, 1, 0, 6'h02, 32'h100, 32'h100, 33'h200, 32'h0FE, 32'h1100);
        drive(0, 0, 1, 0, 6'h02, 32'h100, 32'h100, 33'h201, 32'h100, 32'h1100);
        drive(0, 0, 1, 0, 6'h02, 32'h100, 32'h100, 33'h200, 32'h100, 32'h1100);
        drive(0, 0, 1, 0, 6'h02, 32'h100, 32'h100, 33'h200, 32'hFFFF_FFFE, 32'h1100);
        // R1 wrap and bit0 clear; R2 address kept
        drive(0, 1, 1, 0, 6'h02, 32'hFFFF_FFF0, 32'h0, 33'h1_0000_0000, 32'h15, 32'h1200);
        // R3 top of address space with 33-bit top
        drive(0, 0, 1, 0, 6'h02, 32'hFFFF_FFFE, 32'hFFFF_0000, 33'h1_0000_0000, 32'h0, 32'h1200);
        // R4 odd base and target bit1 set accepted
        drive(0, 0, 1, 0, 6'h02, 32'h301, 32'h301, 33'h400, 32'h1, 32'h1300);
        // R5 tag clear, no exec, bad otype; sealed sentry allowed
        drive(0, 0, 0, 0, 6'h02, 32'h100, 32'h100, 33'h200, 32'h0, 32'h1100);
        drive(0, 0, 1, 0, 6'h3d, 32'h100, 32'h100, 33'h200, 32'h0, 32'h1100);
        drive(0, 0, 1, 5, 6'h02, 32'h100, 32'h100, 33'h200, 32'h0, 32'h1100);
        drive(0, 0, 1, 2, 6'h02, 32'h100, 32'h100, 33'h200, 32'h0, 32'h1100);
        // R6 both causes
        drive(0, 0, 0, 0, 6'h00, 32'h100, 32'h100, 33'h200, 32'h800, 32'h1100);
        // direct jumps: in bounds, out of bounds, compressed link
        drive(1, 0, 0, 7, 6'h00, 32'h0, 32'h0, 33'h0, 32'h10, 32'h1100);
        drive(1, 1, 0, 0, 6'h00, 32'h0, 32'h0, 33'h0, 32'hF00, 32'h1100);
        drive(1, 1, 1, 0, 6'h02, 32'h0, 32'h0, 33'h0, 32'hFFFF_FFF0, 32'h1008);
        // random
        for (int i = 0; i < 300; i++) begin
            logic [31:0] b;
            b = $urandom & 32'h0000_FFFF;
            drive(1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 4)),
                  6'($urandom) | 6'h02, b + 32'($urandom_range(0, 64)), b,
                  33'(b) + 33'($urandom_range(0, 128)), 32'($urandom_range(0, 80)) - 32'd8,
                  32'h1000 + 32'($urandom_range(0, 4096)));
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9 drain", 33'(sb.size()), 33'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule